// File: doc/BRIEF.md
# Flash Status Register Unit

This block sits on the device side of a NOR flash model. It keeps a 16-bit status word that describes the embedded program or erase operation, and it can place that word in the path of a single read. When a status-read command arrives with a sector number, the unit arms a one-shot overlay for that sector. The next read that falls in that sector returns the status word in place of array data, and the overlay then disarms. Reads to any other sector pass the array data through and leave the overlay armed.

The lower byte of the word holds ready, suspend and failure flags. The failure flags and the sector-lock error flag are sticky: they survive later operations and are cleared only by the clear-status command. While an operation is running, the upper byte shows a phase code supplied by the operation engine, and the lower flags read as zero because they are not valid in that state. Commands arrive as one-cycle decode strobes. Operation events arrive as one-cycle pulses from the engine. Each read request is answered one cycle later.

Top module: `flash_status_unit`

## Requirements
- R1: After reset, no read response is pending, the overlay is disarmed (the first read returns array data), the operation state is idle and every result flag is 0, so the first status read returns 16'h0080.
- R2: Bit 7 (ready) is 0 while an operation runs and 1 otherwise. `op_start` is accepted only when idle, and `op_erase` selects erase (1) or program (0). `op_done` ends a running operation. Suspend, resume and done pulses that do not match the current state and kind have no effect.
- R3: After `cmd_stat_rd` with sector S, exactly the next read whose sector equals S returns the status word. Later reads to S return `arr_data`.
- R4: A read to a sector other than the armed one returns `arr_data` and leaves the overlay armed.
- R5: `cmd_clr_stat` or `cmd_other` disarms a pending overlay. A new `cmd_stat_rd` re-arms it with its own sector.
- R6: `op_done` with `op_fail` sets bit 5 for an erase or bit 4 for a program. These bits stay set through later operations, whether they pass or fail, until `cmd_clr_stat`.
- R7: A `lock_viol` pulse sets bit 1, which stays set until `cmd_clr_stat`. If both arrive in the same cycle, the set wins.
- R8: Suspending a running erase (`susp_ers`) sets bit 6, and suspending a running program (`susp_pgm`) sets bit 2. A suspended operation reads as ready. A matching resume returns it to running.
- R9: While bit 7 is 0, bits 6..0 read 0 and bits 15..8 equal `phase_code`. While bit 7 is 1, bits 15..8 read 0. Bits 3 and 0 always read 0.
- R10: `rd_valid` is high exactly one cycle after each `rd_req`, and `rd_data` holds the response in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_stat_rd | input | 1 | Status-read command strobe; arms the overlay |
| cmd_clr_stat | input | 1 | Clear-status command strobe |
| cmd_other | input | 1 | Strobe for any other decoded command |
| cmd_sect | input | SECT_W | Sector number sent with the status-read command |
| op_start | input | 1 | Engine begins an operation |
| op_erase | input | 1 | Kind for op_start: 1 erase, 0 program |
| op_done | input | 1 | Engine finished the running operation |
| op_fail | input | 1 | Qualifies op_done as a failure |
| susp_pgm | input | 1 | Program suspended |
| susp_ers | input | 1 | Erase suspended |
| resume_pgm | input | 1 | Program resumed |
| resume_ers | input | 1 | Erase resumed |
| lock_viol | input | 1 | Access to a locked sector was attempted |
| phase_code | input | 8 | Current phase of the running operation |
| rd_req | input | 1 | Read request |
| rd_sect | input | SECT_W | Sector number of the read address |
| arr_data | input | 16 | Array data for the read |
| rd_valid | output | 1 | Response valid, one cycle after rd_req |
| rd_data | output | 16 | Read response |

## Verification
The hardest case to reach is a status read that returns sticky failure or lock flags after later operations have run. For this, a failed completion has to be followed by a new start and a passing completion, with no clear command in between, and then by a freshly armed overlay and a read in the same sector. Directed sequences build these chains on purpose, including a suspend of the wrong kind and a read to an unarmed sector between arm and hit. The random phase limits its sectors to four values so that arm-and-hit pairs occur often, and it mixes operation events with clear commands so that flags are set and cleared in many orders.

// File: rtl/fsu_pkg.sv
// Shared types and bit positions for the flash status register unit.
// Assumes a 16-bit status word: result flags in the low byte, phase in the high byte.
package fsu_pkg;
    localparam int WORD_W  = 16;
    localparam int PHASE_W = WORD_W / 2;

    localparam int B_READY    = 7;
    localparam int B_ERS_SUSP = 6;
    localparam int B_ERS_FAIL = 5;
    localparam int B_PGM_FAIL = 4;
    localparam int B_PGM_SUSP = 2;
    localparam int B_LOCK     = 1;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RUN  = 2'd1,
        OP_SUSP = 2'd2
    } op_state_t;

    typedef struct packed {
        logic ers_fail;
        logic pgm_fail;
        logic lock_err;
    } result_t;
endpackage

// File: rtl/fsu_op_tracker.sv
// Tracks the embedded operation (idle, running, suspended), its kind, and the
// sticky result flags. Assumes the engine's event pulses last one cycle.
// Events that do not fit the current state or kind are ignored.
module fsu_op_tracker
    import fsu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      op_start,
    input  logic      op_erase,
    input  logic      op_done,
    input  logic      op_fail,
    input  logic      susp_pgm,
    input  logic      susp_ers,
    input  logic      resume_pgm,
    input  logic      resume_ers,
    input  logic      lock_viol,
    input  logic      clr,
    output op_state_t state_o,
    output logic      is_erase_o,
    output result_t   res_o
);
    op_state_t state_q;
    logic      erase_q;
    result_t   res_q;

    logic    susp_hit;
    logic    resume_hit;
    logic    done_hit;
    result_t res_set;

    // Decode which events apply to the current operation.
    always_comb begin
        done_hit   = (state_q == OP_RUN) && op_done;
        susp_hit   = (state_q == OP_RUN) && !op_done &&
                     (erase_q ? susp_ers : susp_pgm);
        resume_hit = (state_q == OP_SUSP) && (erase_q ? resume_ers : resume_pgm);
        res_set.ers_fail = done_hit && op_fail && erase_q;
        res_set.pgm_fail = done_hit && op_fail && !erase_q;
        res_set.lock_err = lock_viol;
    end

    // Operation state and kind register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OP_IDLE;
            erase_q <= 1'b0;
        end else begin
            unique case (state_q)
                OP_IDLE: if (op_start) begin
                    state_q <= OP_RUN;
                    erase_q <= op_erase;
                end
                OP_RUN: begin
                    if (done_hit)      state_q <= OP_IDLE;
                    else if (susp_hit) state_q <= OP_SUSP;
                end
                OP_SUSP: if (resume_hit) state_q <= OP_RUN;
                default: state_q <= OP_IDLE;
            endcase
        end
    end

    // Sticky result flags: clear first, then any new set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= (clr ? result_t'('0) : res_q) | res_set;
    end

    assign state_o    = state_q;
    assign is_erase_o = erase_q;
    assign res_o      = res_q;
endmodule

// File: rtl/fsu_overlay.sv
// One-shot read overlay. A status-read command arms it for one sector. The
// first read that hits that sector consumes it. Any other command disarms it.
module fsu_overlay #(
    parameter int SECT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              disarm_cmd,
    input  logic [SECT_W-1:0] arm_sect,
    input  logic              rd_req,
    input  logic [SECT_W-1:0] rd_sect,
    output logic              hit_o,
    output logic              armed_o
);
    logic              armed_q;
    logic [SECT_W-1:0] sect_q;

    // A read hits when the overlay is armed and the sector matches.
    assign hit_o = armed_q && rd_req && (sect_q == rd_sect);

    // Arm, consume and disarm the overlay; the arm command takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            sect_q  <= '0;
        end else if (arm) begin
            armed_q <= 1'b1;
            sect_q  <= arm_sect;
        end else if (disarm_cmd || hit_o) begin
            armed_q <= 1'b0;
        end
    end

    assign armed_o = armed_q;
endmodule

// File: rtl/flash_status_unit.sv
// Top of the status register unit. Builds the 16-bit status word from the
// operation tracker and the phase code, and returns it for one overlay hit or
// array data otherwise. Assumes command strobes and event pulses last one cycle.
module flash_status_unit
    import fsu_pkg::*;
#(
    parameter int SECT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_stat_rd,
    input  logic                cmd_clr_stat,
    input  logic                cmd_other,
    input  logic [SECT_W-1:0]   cmd_sect,
    input  logic                op_start,
    input  logic                op_erase,
    input  logic                op_done,
    input  logic                op_fail,
    input  logic                susp_pgm,
    input  logic                susp_ers,
    input  logic                resume_pgm,
    input  logic                resume_ers,
    input  logic                lock_viol,
    input  logic [PHASE_W-1:0]  phase_code,
    input  logic                rd_req,
    input  logic [SECT_W-1:0]   rd_sect,
    input  logic [WORD_W-1:0]   arr_data,
    output logic                rd_valid,
    output logic [WORD_W-1:0]   rd_data
);
    op_state_t         op_state;
    logic              op_is_erase;
    result_t           res;
    logic              ov_hit;
    logic              ov_armed;
    logic [WORD_W-1:0] stat_word;

    fsu_op_tracker u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_start   (op_start),
        .op_erase   (op_erase),
        .op_done    (op_done),
        .op_fail    (op_fail),
        .susp_pgm   (susp_pgm),
        .susp_ers   (susp_ers),
        .resume_pgm (resume_pgm),
        .resume_ers (resume_ers),
        .lock_viol  (lock_viol),
        .clr        (cmd_clr_stat),
        .state_o    (op_state),
        .is_erase_o (op_is_erase),
        .res_o      (res)
    );

    fsu_overlay #(.SECT_W(SECT_W)) u_ovl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (cmd_stat_rd),
        .disarm_cmd (cmd_clr_stat || cmd_other),
        .arm_sect   (cmd_sect),
        .rd_req     (rd_req),
        .rd_sect    (rd_sect),
        .hit_o      (ov_hit),
        .armed_o    (ov_armed)
    );

    // Build the status word; the low flags are shown only when ready.
    always_comb begin
        stat_word = '0;
        if (op_state == OP_RUN) begin
            stat_word[WORD_W-1:PHASE_W] = phase_code;
        end else begin
            stat_word[B_READY]    = 1'b1;
            stat_word[B_ERS_SUSP] = (op_state == OP_SUSP) && op_is_erase;
            stat_word[B_PGM_SUSP] = (op_state == OP_SUSP) && !op_is_erase;
            stat_word[B_ERS_FAIL] = res.ers_fail;
            stat_word[B_PGM_FAIL] = res.pgm_fail;
            stat_word[B_LOCK]     = res.lock_err;
        end
    end

    // Register the read response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= ov_hit ? stat_word : arr_data;
        end
    end
endmodule

// File: rtl/fsu_checker.sv
// Assertion checker for flash_status_unit, attached with bind below.
module fsu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_req,
    input logic       rd_valid,
    input logic       hit,
    input logic       armed,
    input logic       cmd_stat_rd,
    input logic       cmd_clr_stat,
    input logic       cmd_other,
    input logic       pgm_fail,
    input logic       lock_err,
    input logic       lock_viol,
    input logic [1:0] susp_bits
);
    a_r10_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    a_r10_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    a_r3_hit_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cmd_stat_rd) |=> !armed);
    a_r4_miss_keeps_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rd_req && !hit && !cmd_clr_stat && !cmd_other) |=> armed);
    a_r5_cmd_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_clr_stat || cmd_other) && !cmd_stat_rd) |=> !armed);
    a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_fail && !cmd_clr_stat) |=> pgm_fail);
    a_r7_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
        lock_viol |=> lock_err);
    a_r8_one_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(susp_bits));
endmodule

bind flash_status_unit fsu_checker u_fsu_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req       (rd_req),
    .rd_valid     (rd_valid),
    .hit          (ov_hit),
    .armed        (ov_armed),
    .cmd_stat_rd  (cmd_stat_rd),
    .cmd_clr_stat (cmd_clr_stat),
    .cmd_other    (cmd_other),
    .pgm_fail     (res.pgm_fail),
    .lock_err     (res.lock_err),
    .lock_viol    (lock_viol),
    .susp_bits    ({stat_word[6], stat_word[2]})
);

// File: tb/flash_status_unit_bench.sv
module flash_status_unit_bench;
    localparam int SW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_stat_rd = 0, cmd_clr_stat = 0, cmd_other = 0;
    logic [SW-1:0] cmd_sect = '0;
    logic op_start = 0, op_erase = 0, op_done = 0, op_fail = 0;
    logic susp_pgm = 0, susp_ers = 0, resume_pgm = 0, resume_ers = 0, lock_viol = 0;
    logic [7:0] phase_code = '0;
    logic rd_req = 0;
    logic [SW-1:0] rd_sect = '0;
    logic [15:0] arr_data = '0;
    logic rd_valid;
    logic [15:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done_flag = 0;

    // Reference model state
    int   m_state = 0;   // 0 idle, 1 running, 2 suspended
    bit   m_ers = 0, m_ef = 0, m_pf = 0, m_lk = 0, m_armed = 0;
    logic [SW-1:0] m_sect = '0;

    always #10 clk = ~clk;

    flash_status_unit #(.SECT_W(SW)) u_flash_status_unit (
        .clk(clk), .rst_n(rst_n), .cmd_stat_rd(cmd_stat_rd), .cmd_clr_stat(cmd_clr_stat),
        .cmd_other(cmd_other), .cmd_sect(cmd_sect), .op_start(op_start), .op_erase(op_erase),
        .op_done(op_done), .op_fail(op_fail), .susp_pgm(susp_pgm), .susp_ers(susp_ers),
        .resume_pgm(resume_pgm), .resume_ers(resume_ers), .lock_viol(lock_viol),
        .phase_code(phase_code), .rd_req(rd_req), .rd_sect(rd_sect), .arr_data(arr_data),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [15:0] exp_word();
        if (m_state == 1) return {phase_code, 8'h00};
        return {8'h00, 1'b1, (m_state == 2) && m_ers, m_ef, m_pf,
                1'b0, (m_state == 2) && !m_ers, m_lk, 1'b0};
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic release_all();
        cmd_stat_rd = 0; cmd_clr_stat = 0; cmd_other = 0;
        op_start = 0; op_done = 0; op_fail = 0;
        susp_pgm = 0; susp_ers = 0; resume_pgm = 0; resume_ers = 0; lock_viol = 0;
        rd_req = 0;
    endtask

    task automatic do_cmd(int kind, logic [SW-1:0] s);
        @(negedge clk);
        cmd_sect = s;
        if (kind == 0) begin cmd_stat_rd = 1; m_armed = 1; m_sect = s; end
        else if (kind == 1) begin cmd_clr_stat = 1; m_armed = 0; m_ef = 0; m_pf = 0; m_lk = 0; end
        else begin cmd_other = 1; m_armed = 0; end
        @(negedge clk);
        release_all();
    endtask

    task automatic do_start(bit ers);
        @(negedge clk);
        op_start = 1; op_erase = ers;
        if (m_state == 0) begin m_state = 1; m_ers = ers; end
        @(negedge clk);
        release_all();
    endtask

    task automatic do_done(bit fail);
        @(negedge clk);
        op_done = 1; op_fail = fail;
        if (m_state == 1) begin
            m_state = 0;
            if (fail) begin if (m_ers) m_ef = 1; else m_pf = 1; end
        end
        @(negedge clk);
        release_all();
    endtask

    task automatic do_susp(bit ers, bit resume);
        @(negedge clk);
        if (resume) begin
            if (ers) resume_ers = 1; else resume_pgm = 1;
            if (m_state == 2 && m_ers == ers) m_state = 1;
        end else begin
            if (ers) susp_ers = 1; else susp_pgm = 1;
            if (m_state == 1 && m_ers == ers) m_state = 2;
        end
        @(negedge clk);
        release_all();
    endtask

    task automatic do_lock();
        @(negedge clk);
        lock_viol = 1; m_lk = 1;
        @(negedge clk);
        release_all();
    endtask

    task automatic do_read(string tag, logic [SW-1:0] s);
        logic [15:0] exp;
        @(negedge clk);
        rd_req = 1; rd_sect = s;
        arr_data = 16'($urandom);
        if (m_armed && m_sect == s) begin exp = exp_word(); m_armed = 0; end
        else exp = arr_data;
        @(negedge clk);
        release_all();
        check({tag, " valid"}, {15'd0, rd_valid}, 16'd1);
        check(tag, rd_data, exp);
    endtask

    // Arm the overlay for a sector, read it, and check against a fixed value.
    task automatic stat_expect(string tag, logic [15:0] exp);
        do_cmd(0, 8'h10);
        do_read(tag, 8'h10);
        check({tag, " fixed"}, rd_data, exp);
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 rd_valid after reset", {15'd0, rd_valid}, 16'd0);
        do_read("R1 unarmed read", 8'h02);
        stat_expect("R1 R2 idle status", 16'h0080);
        // R10: valid drops when no request
        @(negedge clk);
        check("R10 idle valid", {15'd0, rd_valid}, 16'd0);
        // R3: single hit then array
        do_cmd(0, 8'h03);
        do_read("R3 first hit", 8'h03);
        check("R3 hit value", rd_data, 16'h0080);
        do_read("R3 second read array", 8'h03);
        // R4: miss keeps armed
        do_cmd(0, 8'h01);
        do_read("R4 other sector", 8'h05);
        do_read("R4 later hit", 8'h01);
        check("R4 hit value", rd_data, 16'h0080);
        // R5: other commands disarm
        do_cmd(0, 8'h04); do_cmd(2, 8'h00);
        do_read("R5 after other cmd", 8'h04);
        do_cmd(0, 8'h04); do_cmd(1, 8'h00);
        do_read("R5 after clear cmd", 8'h04);
        // R2 R9: running shows phase
        phase_code = 8'h3C;
        do_start(0);
        stat_expect("R2 R9 running", 16'h3C00);
        // R6: sticky program failure
        do_done(1);
        stat_expect("R6 program failed", 16'h0090);
        do_start(1); do_done(0);
        stat_expect("R6 sticky after pass", 16'h0090);
        do_cmd(1, 8'h00);
        stat_expect("R6 cleared", 16'h0080);
        // R8: suspend and resume
        phase_code = 8'h5A;
        do_start(1);
        do_susp(0, 0);
        stat_expect("R8 wrong-kind suspend ignored", 16'h5A00);
        do_susp(1, 0);
        stat_expect("R8 erase suspended", 16'h00C0);
        do_susp(1, 1);
        stat_expect("R8 resumed", 16'h5A00);
        do_done(1);
        stat_expect("R6 erase failed", 16'h00A0);
        do_start(0); do_susp(0, 0);
        stat_expect("R8 program suspended", 16'h00A4);
        do_susp(0, 1); do_done(0);
        // R7: lock error
        do_lock();
        stat_expect("R7 lock set", 16'h00A2);
        do_cmd(1, 8'h00);
        stat_expect("R7 lock cleared", 16'h0080);
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            int pick = $urandom_range(0, 19);
            logic [SW-1:0] s = SW'($urandom_range(0, 3));
            if (pick < 7)       do_read("R3/R4 random read", s);
            else if (pick < 10) do_cmd(0, s);
            else if (pick == 10) do_cmd(1, s);
            else if (pick == 11) do_cmd(2, s);
            else if (pick == 12) do_start(1'($urandom));
            else if (pick == 13) do_done(1'($urandom));
            else if (pick == 14) do_susp(1'($urandom), 1'b0);
            else if (pick == 15) do_susp(1'($urandom), 1'b1);
            else if (pick == 16) do_lock();
            else begin
                @(negedge clk);
                phase_code = 8'($urandom);
            end
        end
        done_flag = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule